// File: doc/BRIEF.md
# Ethernet receive ring buffer manager

This block files received Ethernet frames into a circular receive region of an on-chip byte memory. Frame bytes arrive on a plain byte stream, one per cycle when `rx_valid` is high, with `rx_last` marking the final byte and `rx_ok` giving the frame's validity together with that byte. Payload bytes are written first, starting six bytes past the current write position. Once the frame is complete, a six-byte little-endian header is written into the reserved gap. The header holds, in this order, the next-packet pointer, the byte count and a status word.

Software sees a small host port. Through it, software programs the ring bounds and sets an auto-incrementing buffer read pointer, then reads headers and payload one byte per request. It releases space by moving a read-limit pointer, which marks the last byte it still holds, and it lowers the pending-packet count with an explicit decrement command. A frame that would run over the read limit is discarded and raises a sticky overflow flag. A frame longer than the maximum length is discarded without the flag. The default memory is 2 KB, with the lower three quarters (bytes 0 to 1535) used as the receive ring after reset.

Top module: `rxr_ring_top`

## Requirements
- R1: After reset, `pkt_count` is 0, `rx_overflow` is 0, `rx_wr_ptr` is 0 and `rd_limit` is 1535. The ring bounds are 0 and 1535 and the buffer read pointer is 0.
- R2: A stored frame occupies 6+N consecutive ring bytes starting at the old `rx_wr_ptr`. Bytes 0-1 are the next-packet pointer (low byte first), bytes 2-3 are the payload length N (low byte first), bytes 4-5 are the status word, and the N payload bytes follow. `rx_wr_ptr` then moves to the next-packet pointer.
- R3: The status word has bit 7 equal to the `rx_ok` value given with the frame's last byte, and all other bits 0. Frames with `rx_ok`=0 are still stored.
- R4: `pkt_count` rises by 1 for each stored frame. It falls by 1 for each host write with `hst_sel`=4, and a decrement at 0 leaves it at 0.
- R5: A frame of more than MAX_FRAME (1518) bytes is discarded: `rx_wr_ptr` and `pkt_count` are unchanged and `rx_overflow` is not set. A frame of exactly 1518 bytes is stored.
- R6: Header and payload writes wrap from the end bound to the start bound, and the next-packet pointer always lies inside the ring.
- R7: A frame whose 6+N bytes would reach the byte at `rd_limit` is discarded, leaving `rx_wr_ptr` and `pkt_count` unchanged, and sets `rx_overflow`. The flag holds until a host write with `hst_sel`=5.
- R8: A host write with `hst_sel`=3 sets `rd_limit` to the written value. A value below the start bound or above the end bound sets it to the end bound instead.
- R9: A host write with `hst_sel`=2 sets the buffer read pointer. Each `hst_re` pulse returns the byte at the pointer on `hst_rdata` one cycle later and advances the pointer, which wraps from the end bound to the start bound.
- R10: A host write with `hst_sel`=0 (start bound) or `hst_sel`=1 (end bound) sets that bound. In the following cycle, `rx_wr_ptr` moves to the start bound and `rd_limit` moves to the end bound.
- R11: A frame whose first byte arrives while the previous frame's header is still being written (within 6 cycles of its last byte) is ignored up to and including its last byte, with no flag and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Frame byte present this cycle |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_ok | input | 1 | Frame validity, taken with the final byte |
| hst_we | input | 1 | Host register write / command strobe |
| hst_sel | input | 3 | 0 start bound, 1 end bound, 2 read pointer, 3 read limit, 4 packet decrement, 5 overflow clear |
| hst_wdata | input | ADDR_W | Host write value |
| hst_re | input | 1 | Read one buffer byte and advance the read pointer |
| hst_rdata | output | 8 | Byte read, valid the cycle after `hst_re` |
| pkt_count | output | 8 | Pending packet count |
| rx_overflow | output | 1 | Sticky flag for a frame dropped for lack of space |
| rx_wr_ptr | output | ADDR_W | Position where the next frame's header goes |
| rd_limit | output | ADDR_W | Last ring byte still held by the host |

## Verification
The assertions check on every cycle that the packet count moves by at most one step, that the write pointer and read limit stay inside the ring bounds outside a bound reload, and that the overflow flag stays set until it is cleared and never appears together with a moved write pointer. The byte layout of the header, the status bit, wrap-around of both the write and read pointers, the length limit, the exact space boundary, read-limit clamping and the loss of a frame that arrives during a header commit are shown only by the bench's scenarios, which read the ring back through the host port.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int HDR_BYTES  = 6;
  localparam int STAT_OK_BIT = 7;

  localparam logic [2:0] SEL_START  = 3'd0;
  localparam logic [2:0] SEL_END    = 3'd1;
  localparam logic [2:0] SEL_RPTR   = 3'd2;
  localparam logic [2:0] SEL_RLIM   = 3'd3;
  localparam logic [2:0] SEL_PKTDEC = 3'd4;
  localparam logic [2:0] SEL_OVFCLR = 3'd5;

  typedef enum logic [1:0] {W_IDLE, W_RECV, W_HDR, W_DROP} wr_state_e;
endpackage

// File: rtl/rxr_mem.sv
module rxr_mem #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= 8'h00;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rxr_writer.sv
module rxr_writer
  import rxr_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int MAX_FRAME = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_ok,
  input  logic [ADDR_W-1:0] ring_start,
  input  logic [ADDR_W-1:0] ring_end,
  input  logic [ADDR_W-1:0] rd_limit,
  input  logic              reload,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic              commit,
  output logic              ovf_set,
  output logic [ADDR_W-1:0] wr_ptr
);
  localparam int LEN_W = $clog2(MAX_FRAME + 2);
  localparam int CW    = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 2;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                             input logic [ADDR_W-1:0] s,
                                             input logic [ADDR_W-1:0] e);
    return (a == e) ? s : a + 1'b1;
  endfunction

  wr_state_e         st_q, st_d;
  logic [ADDR_W-1:0] wp_q, wp_d, pa_q, pa_d, ha_q, ha_d;
  logic [LEN_W-1:0]  len_q, len_d, len_n;
  logic              ok_q, ok_d, skip_q, skip_d;
  logic [2:0]        k_q, k_d;

  logic [CW-1:0] size_w, dist_w, used_w, base_w;
  logic [CW-1:0] wp_w, lim_w, end_w;
  logic [15:0]   nxt16, len16;
  logic          drop, no_room;

  assign wp_w   = CW'(wp_q);
  assign lim_w  = CW'(rd_limit);
  assign end_w  = CW'(ring_end);
  assign size_w = end_w - CW'(ring_start) + 1'b1;
  assign dist_w = (lim_w >= wp_w) ? (lim_w - wp_w) : (lim_w + size_w - wp_w);
  assign base_w = ((wp_w + CW'(HDR_BYTES)) > end_w) ? (wp_w + CW'(HDR_BYTES) - size_w)
                                                    : (wp_w + CW'(HDR_BYTES));
  assign len_n  = (st_q == W_IDLE) ? LEN_W'(1) : len_q + 1'b1;
  assign used_w = CW'(HDR_BYTES) + CW'(len_n);
  assign no_room = used_w > dist_w;
  assign nxt16  = 16'(pa_q);
  assign len16  = 16'(len_q);
  assign wr_ptr = wp_q;

  always_comb begin
    st_d = st_q; wp_d = wp_q; pa_d = pa_q; ha_d = ha_q;
    len_d = len_q; ok_d = ok_q; k_d = k_q; skip_d = skip_q;
    mem_we = 1'b0; mem_waddr = pa_q; mem_wdata = rx_data;
    commit = 1'b0; ovf_set = 1'b0; drop = 1'b0;
    case (st_q)
      W_IDLE, W_RECV: begin
        if (rx_valid) begin
          if (st_q == W_RECV && len_n > LEN_W'(MAX_FRAME)) begin
            drop = 1'b1;
          end else if (no_room) begin
            drop = 1'b1;
            ovf_set = 1'b1;
          end else begin
            mem_we    = 1'b1;
            mem_waddr = (st_q == W_IDLE) ? base_w[ADDR_W-1:0] : pa_q;
            pa_d      = step(mem_waddr, ring_start, ring_end);
            len_d     = len_n;
            ok_d      = rx_ok;
            if (rx_last) begin
              st_d = W_HDR; k_d = 3'd0; ha_d = wp_q; skip_d = 1'b0;
            end else begin
              st_d = W_RECV;
            end
          end
          if (drop) st_d = rx_last ? W_IDLE : W_DROP;
        end
      end
      W_HDR: begin
        mem_we    = 1'b1;
        mem_waddr = ha_q;
        ha_d      = step(ha_q, ring_start, ring_end);
        case (k_q)
          3'd0:    mem_wdata = nxt16[7:0];
          3'd1:    mem_wdata = nxt16[15:8];
          3'd2:    mem_wdata = len16[7:0];
          3'd3:    mem_wdata = len16[15:8];
          3'd4:    mem_wdata = 8'(ok_q) << STAT_OK_BIT;
          default: mem_wdata = 8'h00;
        endcase
        if (rx_valid) skip_d = !rx_last;
        if (k_q == 3'd5) begin
          commit = 1'b1;
          wp_d   = pa_q;
          st_d   = skip_d ? W_DROP : W_IDLE;
        end else begin
          k_d = k_q + 1'b1;
        end
      end
      default: begin
        if (rx_valid && rx_last) st_d = W_IDLE;
      end
    endcase
    if (reload) wp_d = ring_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= W_IDLE; wp_q <= '0; pa_q <= '0; ha_q <= '0;
      len_q <= '0; ok_q <= 1'b0; k_q <= '0; skip_q <= 1'b0;
    end else begin
      st_q <= st_d; wp_q <= wp_d; pa_q <= pa_d; ha_q <= ha_d;
      len_q <= len_d; ok_q <= ok_d; k_q <= k_d; skip_q <= skip_d;
    end
  end
endmodule

// File: rtl/rxr_host.sv
module rxr_host
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_we,
  input  logic [2:0]        hst_sel,
  input  logic [ADDR_W-1:0] hst_wdata,
  input  logic              hst_re,
  input  logic              commit,
  input  logic              ovf_set,
  output logic [ADDR_W-1:0] ring_start,
  output logic [ADDR_W-1:0] ring_end,
  output logic [ADDR_W-1:0] rd_limit,
  output logic              reload,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic [7:0]        pkt_count,
  output logic              overflow
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] END_RST = ADDR_W'((DEPTH * 3) / 4 - 1);

  logic [ADDR_W-1:0] start_q, start_d, end_q, end_d, rlim_q, rlim_d, rptr_q, rptr_d;
  logic              reload_q, reload_d, ovf_q, ovf_d, dec, clr, ptr_wr;
  logic [7:0]        cnt_q, cnt_d;

  always_comb begin
    start_d = start_q; end_d = end_q; rlim_d = rlim_q; rptr_d = rptr_q;
    reload_d = 1'b0; dec = 1'b0; clr = 1'b0;
    ptr_wr = hst_we && (hst_sel == SEL_RPTR);
    if (hst_we) begin
      case (hst_sel)
        SEL_START:  begin start_d = hst_wdata; reload_d = 1'b1; end
        SEL_END:    begin end_d = hst_wdata;   reload_d = 1'b1; end
        SEL_RPTR:   rptr_d = hst_wdata;
        SEL_RLIM:   rlim_d = (hst_wdata < start_q || hst_wdata > end_q) ? end_q : hst_wdata;
        SEL_PKTDEC: dec = 1'b1;
        SEL_OVFCLR: clr = 1'b1;
        default:    ;
      endcase
    end
    if (reload_q) rlim_d = end_q;
    if (hst_re && !ptr_wr) rptr_d = (rptr_q == end_q) ? start_q : rptr_q + 1'b1;
    cnt_d = cnt_q + 8'(commit) - 8'(dec && (cnt_q != 8'd0));
    ovf_d = ovf_set ? 1'b1 : (clr ? 1'b0 : ovf_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0; end_q <= END_RST; rlim_q <= END_RST; rptr_q <= '0;
      reload_q <= 1'b0; ovf_q <= 1'b0; cnt_q <= 8'd0;
    end else begin
      start_q <= start_d; end_q <= end_d; rlim_q <= rlim_d; rptr_q <= rptr_d;
      reload_q <= reload_d; ovf_q <= ovf_d; cnt_q <= cnt_d;
    end
  end

  assign ring_start = start_q;
  assign ring_end   = end_q;
  assign rd_limit   = rlim_q;
  assign reload     = reload_q;
  assign mem_re     = hst_re;
  assign mem_raddr  = rptr_q;
  assign pkt_count  = cnt_q;
  assign overflow   = ovf_q;
endmodule

// File: rtl/rxr_ring_top.sv
module rxr_ring_top #(
  parameter int ADDR_W    = 11,
  parameter int MAX_FRAME = 1518
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              rx_last,
  input  logic              rx_ok,
  input  logic              hst_we,
  input  logic [2:0]        hst_sel,
  input  logic [ADDR_W-1:0] hst_wdata,
  input  logic              hst_re,
  output logic [7:0]        hst_rdata,
  output logic [7:0]        pkt_count,
  output logic              rx_overflow,
  output logic [ADDR_W-1:0] rx_wr_ptr,
  output logic [ADDR_W-1:0] rd_limit
);
  logic [1:0]        rst_sync;
  logic              rst_ns;
  logic [ADDR_W-1:0] ring_start, ring_end, mem_waddr, mem_raddr;
  logic [7:0]        mem_wdata;
  logic              reload, mem_we, mem_re, commit, ovf_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  rxr_writer #(.ADDR_W(ADDR_W), .MAX_FRAME(MAX_FRAME)) u_writer (
    .clk(clk), .rst_n(rst_ns), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ok(rx_ok), .ring_start(ring_start), .ring_end(ring_end),
    .rd_limit(rd_limit), .reload(reload), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .commit(commit), .ovf_set(ovf_set), .wr_ptr(rx_wr_ptr)
  );

  rxr_host #(.ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_ns), .hst_we(hst_we), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_re(hst_re), .commit(commit), .ovf_set(ovf_set),
    .ring_start(ring_start), .ring_end(ring_end), .rd_limit(rd_limit),
    .reload(reload), .mem_re(mem_re), .mem_raddr(mem_raddr),
    .pkt_count(pkt_count), .overflow(rx_overflow)
  );

  rxr_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_ns), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(mem_raddr), .rdata(hst_rdata)
  );
endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_ns,
  input logic [7:0]        pkt_count,
  input logic              rx_overflow,
  input logic [ADDR_W-1:0] rx_wr_ptr,
  input logic [ADDR_W-1:0] rd_limit,
  input logic [ADDR_W-1:0] ring_start,
  input logic [ADDR_W-1:0] ring_end,
  input logic              reload,
  input logic              hst_we,
  input logic [2:0]        hst_sel
);
  // R4: the count moves by one step at most per cycle
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_ns)
    1'b1 |=> (pkt_count == $past(pkt_count) || pkt_count == $past(pkt_count) + 8'd1 ||
              pkt_count == $past(pkt_count) - 8'd1));

  // R6: write pointer stays inside the ring
  a_r6_wp_in_ring: assert property (@(posedge clk) disable iff (!rst_ns)
    !reload |-> (rx_wr_ptr >= ring_start && rx_wr_ptr <= ring_end));

  // R8: read limit stays inside the ring
  a_r8_limit_in_ring: assert property (@(posedge clk) disable iff (!rst_ns)
    !reload |-> (rd_limit >= ring_start && rd_limit <= ring_end));

  // R7: overflow flag is sticky until cleared
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    (rx_overflow && !(hst_we && hst_sel == SEL_OVFCLR)) |=> rx_overflow);

  // R7: a dropped frame never moves the write pointer
  a_r7_drop_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(rx_overflow) |-> $stable(rx_wr_ptr));
endmodule

bind rxr_ring_top rxr_ring_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .pkt_count(pkt_count), .rx_overflow(rx_overflow),
  .rx_wr_ptr(rx_wr_ptr), .rd_limit(rd_limit), .ring_start(ring_start),
  .ring_end(ring_end), .reload(reload), .hst_we(hst_we), .hst_sel(hst_sel)
);

// File: tb/test_rxr_ring_top.sv
`timescale 1ns/1ps
module test_rxr_ring_top;
  localparam int AW = 11;
  localparam int RE = 1535;
  localparam int NV = 4;
  localparam int FR_LEN [NV] = '{1, 60, 64, 17};
  localparam int FR_OK  [NV] = '{1, 0, 1, 1};
  localparam int FR_NXT [NV] = '{7, 73, 143, 166};

  logic clk = 1'b0, rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_ok = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic hst_we = 1'b0, hst_re = 1'b0;
  logic [2:0] hst_sel = 3'd0;
  logic [AW-1:0] hst_wdata = '0;
  logic [7:0] hst_rdata, pkt_count;
  logic rx_overflow;
  logic [AW-1:0] rx_wr_ptr, rd_limit;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rxr_ring_top i_rxr_ring_top (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_ok(rx_ok), .hst_we(hst_we), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_re(hst_re), .hst_rdata(hst_rdata),
    .pkt_count(pkt_count), .rx_overflow(rx_overflow), .rx_wr_ptr(rx_wr_ptr),
    .rd_limit(rd_limit)
  );

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 31 + i * 7 + 1) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int len, input bit ok, input int seed, input bit hold);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = pat(seed, i);
      rx_last = (i == len - 1); rx_ok = ok;
    end
    if (!hold) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
    end
  endtask

  task automatic hwr(input logic [2:0] sel, input int val);
    @(negedge clk);
    hst_we = 1'b1; hst_sel = sel; hst_wdata = AW'(val);
    @(negedge clk);
    hst_we = 1'b0;
  endtask

  task automatic hrd(output logic [7:0] b);
    @(negedge clk);
    hst_re = 1'b1;
    @(negedge clk);
    hst_re = 1'b0;
    b = hst_rdata;
  endtask

  // read back one stored frame and compare header and payload
  task automatic check_frame(input string req, input int at, input int nxt,
                             input int len, input bit ok, input int seed);
    logic [7:0] b;
    hwr(3'd2, at);
    hrd(b); chk({req, " next lo"}, b, nxt & 255);
    hrd(b); chk({req, " next hi"}, b, nxt >> 8);
    hrd(b); chk({req, " len lo"}, b, len & 255);
    hrd(b); chk({req, " len hi"}, b, len >> 8);
    hrd(b); chk({req, " R3 status lo"}, b, ok ? 128 : 0);
    hrd(b); chk({req, " R3 status hi"}, b, 0);
    for (int i = 0; i < len; i++) begin
      hrd(b); chk({req, " payload"}, b, pat(seed, i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int wp;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    chk("R1 count", pkt_count, 0);
    chk("R1 overflow", rx_overflow, 0);
    chk("R1 wr_ptr", rx_wr_ptr, 0);
    chk("R1 rd_limit", rd_limit, RE);

    // vector table: store, read back, release
    wp = 0;
    for (int v = 0; v < NV; v++) begin
      send(FR_LEN[v], FR_OK[v] != 0, v, 1'b0);
      idle(10);
      chk("R4 count up", pkt_count, 1);
      chk("R2 wr_ptr", rx_wr_ptr, FR_NXT[v]);
      check_frame("R2", wp, FR_NXT[v], FR_LEN[v], FR_OK[v] != 0, v);
      hwr(3'd3, FR_NXT[v] - 1);
      chk("R8 limit in range", rd_limit, FR_NXT[v] - 1);
      hwr(3'd4, 0);
      idle(1);
      chk("R4 count down", pkt_count, 0);
      wp = FR_NXT[v];
    end

    // R10 bound write rehomes pointers
    hwr(3'd0, 100);
    idle(2);
    chk("R10 wr_ptr", rx_wr_ptr, 100);
    chk("R10 rd_limit", rd_limit, RE);
    hwr(3'd3, 50);
    chk("R8 below start", rd_limit, RE);
    hwr(3'd3, 1600);
    chk("R8 above end", rd_limit, RE);
    hwr(3'd3, 200);
    chk("R8 inside", rd_limit, 200);
    hwr(3'd0, 0);
    idle(2);
    chk("R10 wr_ptr home", rx_wr_ptr, 0);
    chk("R10 rd_limit home", rd_limit, RE);

    // R4 decrement at zero
    hwr(3'd4, 0);
    idle(1);
    chk("R4 dec at zero", pkt_count, 0);

    // R5 length limit
    send(1519, 1'b1, 9, 1'b0);
    idle(10);
    chk("R5 long wr_ptr", rx_wr_ptr, 0);
    chk("R5 long count", pkt_count, 0);
    chk("R5 long no flag", rx_overflow, 0);
    send(1518, 1'b1, 10, 1'b0);
    idle(10);
    chk("R5 max wr_ptr", rx_wr_ptr, 1524);
    chk("R5 max count", pkt_count, 1);
    begin
      logic [7:0] b;
      hwr(3'd2, 2);
      hrd(b); chk("R5 len lo", b, 1518 & 255);
      hrd(b); chk("R5 len hi", b, 1518 >> 8);
    end

    // R7 space boundary: 11 free bytes left
    send(6, 1'b1, 11, 1'b0);
    idle(10);
    chk("R7 flag set", rx_overflow, 1);
    chk("R7 wr_ptr kept", rx_wr_ptr, 1524);
    chk("R7 count kept", pkt_count, 1);
    idle(5);
    chk("R7 flag holds", rx_overflow, 1);
    hwr(3'd5, 0);
    chk("R7 flag cleared", rx_overflow, 0);
    send(5, 1'b1, 12, 1'b0);
    idle(10);
    chk("R7 exact fit wr_ptr", rx_wr_ptr, 1535);
    chk("R7 exact fit count", pkt_count, 2);
    chk("R7 exact fit no flag", rx_overflow, 0);

    // R6 / R9 wrap
    hwr(3'd3, 1534);
    hwr(3'd4, 0);
    hwr(3'd4, 0);
    send(10, 1'b1, 13, 1'b0);
    idle(10);
    chk("R6 wrapped wr_ptr", rx_wr_ptr, 15);
    chk("R6 count", pkt_count, 1);
    check_frame("R6 R9 wrap", 1535, 15, 10, 1'b1, 13);

    // R11 frame starting during header commit is lost
    hwr(3'd3, 14);
    hwr(3'd4, 0);
    send(4, 1'b0, 14, 1'b1);
    send(8, 1'b1, 15, 1'b0);
    idle(12);
    chk("R11 wr_ptr", rx_wr_ptr, 25);
    chk("R11 count", pkt_count, 1);
    chk("R11 no flag", rx_overflow, 0);
    send(3, 1'b1, 16, 1'b0);
    idle(10);
    chk("R11 next frame wr_ptr", rx_wr_ptr, 34);
    chk("R11 next frame count", pkt_count, 2);
    check_frame("R11 first kept", 15, 25, 4, 1'b0, 14);
    check_frame("R11 after gap", 25, 34, 3, 1'b1, 16);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule